// File: doc/BRIEF.md
# Conditional Branch-to-Link Unit

This unit resolves one conditional branch whose destination comes from the link register. A five-bit options field controls four things. It says whether the loop counter steps down. It sets which counter state, zero or nonzero, lets the branch go. It says whether the condition-register test is skipped. It gives the value the selected condition bit must hold. A five-bit selector picks one bit of the 32-bit condition register.

A mode input narrows the counter's zero test to its low 32 bits. The counter itself always decrements across its full width. When a link flag is set, the unit also writes the return address, which is the current address plus the instruction size.

A request is presented with a one-cycle start strobe. One clock later the unit shows four results for one cycle with a done pulse: the updated counter, the updated link value, a taken flag and the next instruction address. All four then hold until the next request. A branch-hint field is accepted and has no effect.

Top module: `cond_link_branch`

## Requirements
- R1: While reset is active and after it is released, done_o, taken_o, next_pc_o, count_o and link_o are all zero until the first request is captured.
- R2: done_o is high for exactly the cycle after each cycle in which start_i is high. Back-to-back requests give back-to-back done pulses. Without start_i, all result outputs keep their values.
- R3: When opt_i[2] (skip-count) is 0, count_o becomes count_i minus 1, wrapping modulo 2^64. When opt_i[2] is 1, count_o becomes count_i unchanged.
- R4: The counter test passes when opt_i[2] is 1. Otherwise it passes when (updated count is nonzero) differs from opt_i[1] (zero polarity). So opt_i[1]=0 branches on nonzero and opt_i[1]=1 branches on zero.
- R5: With wide_mode_i=1 the zero test covers all 64 bits of the updated count. With wide_mode_i=0 it covers only bits [31:0], while the decrement still spans all 64 bits.
- R6: The condition test passes when opt_i[4] (skip-condition) is 1. Otherwise it passes when cond_reg_i[31 - csel_i] equals opt_i[3] (wanted value). Selector 0 names the register's most significant bit.
- R7: taken_o is 1 only when both the counter test and the condition test pass. A taken branch gives next_pc_o equal to link_i with bits [1:0] cleared.
- R8: A branch that is not taken gives next_pc_o equal to pc_i + 4.
- R9: With link_en_i=1, link_o becomes pc_i + 4, taken or not, and the branch target still uses the old link_i. With link_en_i=0, link_o becomes link_i.
- R10: hint_i and opt_i[0] have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request strobe, one cycle per branch |
| opt_i | input | 5 | Options: [4] skip condition, [3] wanted condition value, [2] skip count, [1] zero polarity, [0] unused |
| csel_i | input | 5 | Condition bit selector, 0 = MSB |
| hint_i | input | 2 | Branch hint, ignored |
| link_en_i | input | 1 | Write return address to link |
| wide_mode_i | input | 1 | 1 = 64-bit zero test, 0 = low 32 bits |
| pc_i | input | 64 | Current instruction address |
| count_i | input | 64 | Current loop counter |
| link_i | input | 64 | Current link value |
| cond_reg_i | input | 32 | Condition register |
| done_o | output | 1 | Result valid pulse |
| taken_o | output | 1 | Branch taken |
| next_pc_o | output | 64 | Next instruction address |
| count_o | output | 64 | Updated counter |
| link_o | output | 64 | Updated link value |

## Verification
The hardest case to reach is the narrow zero test. It disagrees with the wide one only when the decremented counter has zero low 32 bits and some nonzero upper bit. To produce that case, the stimulus loads counts such as 0x1_0000_0001 and issues the same request in both modes with the zero polarity set. It also decrements zero to check the full-width wrap. A second hard case is a taken branch with link update. There the target must come from the old link value while the link output changes in the same cycle. The stimulus covers it by issuing requests whose old link value and return address differ in every bit position it checks.

// File: rtl/clb_pkg.sv
package clb_pkg;
   localparam int OPT_W          = 5;
   localparam int OPT_SKIP_COND  = 4;
   localparam int OPT_COND_WANT  = 3;
   localparam int OPT_SKIP_COUNT = 2;
   localparam int OPT_ZERO_POL   = 1;

   typedef struct packed {
      logic skip_cond;
      logic cond_want;
      logic skip_count;
      logic zero_pol;
   } opt_t;
endpackage

// File: rtl/clb_opt_decode.sv
module clb_opt_decode
   import clb_pkg::*;
(
   input  logic [OPT_W-1:0] opt_i,
   output opt_t             dec_o
);
   logic ignored_unused;
   assign ignored_unused = opt_i[0];

   always_comb begin
      dec_o.skip_cond  = opt_i[OPT_SKIP_COND];
      dec_o.cond_want  = opt_i[OPT_COND_WANT];
      dec_o.skip_count = opt_i[OPT_SKIP_COUNT];
      dec_o.zero_pol   = opt_i[OPT_ZERO_POL];
   end
endmodule

// File: rtl/clb_count_eval.sv
module clb_count_eval #(
   parameter int COUNT_W  = 64,
   parameter int NARROW_W = 32
) (
   input  logic [COUNT_W-1:0] count_i,
   input  logic               wide_i,
   input  logic               skip_i,
   input  logic               zero_pol_i,
   output logic [COUNT_W-1:0] count_o,
   output logic               pass_o
);
   localparam logic [COUNT_W-1:0] ONE = COUNT_W'(1);

   logic nonzero;

   if (NARROW_W > COUNT_W || NARROW_W < 1) begin : g_bad_width
      $error("clb_count_eval: NARROW_W must be within 1..COUNT_W");
   end

   assign count_o = skip_i ? count_i : (count_i - ONE);

   if (NARROW_W == COUNT_W) begin : g_single_width
      logic mode_unused;
      assign mode_unused = wide_i;
      assign nonzero     = |count_o;
   end else begin : g_dual_width
      logic nz_full, nz_low;
      assign nz_full = |count_o;
      assign nz_low  = |count_o[NARROW_W-1:0];
      assign nonzero = wide_i ? nz_full : nz_low;
   end

   assign pass_o = skip_i | (nonzero ^ zero_pol_i);
endmodule

// File: rtl/clb_cond_eval.sv
module clb_cond_eval #(
   parameter int COND_W    = 32,
   parameter bit MSB_FIRST = 1'b1,
   localparam int SEL_W    = $clog2(COND_W)
) (
   input  logic [COND_W-1:0] cond_i,
   input  logic [SEL_W-1:0]  sel_i,
   input  logic              skip_i,
   input  logic              want_i,
   output logic              pass_o
);
   localparam logic [SEL_W-1:0] TOP = SEL_W'(COND_W - 1);

   logic [SEL_W-1:0] idx;
   logic             picked;

   if ((1 << SEL_W) != COND_W) begin : g_bad_width
      $error("clb_cond_eval: COND_W must be a power of two");
   end

   if (MSB_FIRST) begin : g_msb_first
      assign idx = TOP - sel_i;
   end else begin : g_lsb_first
      assign idx = sel_i;
   end

   assign picked = cond_i[idx];
   assign pass_o = skip_i | (picked == want_i);
endmodule

// File: rtl/clb_target.sv
module clb_target #(
   parameter int ADDR_W     = 64,
   parameter int STEP       = 4,
   parameter int ALIGN_BITS = 2
) (
   input  logic              taken_i,
   input  logic              link_en_i,
   input  logic [ADDR_W-1:0] pc_i,
   input  logic [ADDR_W-1:0] link_i,
   output logic [ADDR_W-1:0] next_pc_o,
   output logic [ADDR_W-1:0] link_o
);
   localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

   logic [ADDR_W-1:0] seq_pc;
   logic [ADDR_W-1:0] dest;

   if (ALIGN_BITS < 1 || ALIGN_BITS >= ADDR_W) begin : g_bad_align
      $error("clb_target: ALIGN_BITS out of range");
   end

   assign seq_pc    = pc_i + STEP_V;
   assign dest      = {link_i[ADDR_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
   assign next_pc_o = taken_i ? dest : seq_pc;
   assign link_o    = link_en_i ? seq_pc : link_i;
endmodule

// File: rtl/cond_link_branch.sv
module cond_link_branch
   import clb_pkg::*;
#(
   parameter int ADDR_W   = 64,
   parameter int NARROW_W = 32,
   parameter int COND_W   = 32,
   parameter int STEP     = 4,
   parameter int HINT_W   = 2,
   localparam int SEL_W   = $clog2(COND_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [OPT_W-1:0]  opt_i,
   input  logic [SEL_W-1:0]  csel_i,
   input  logic [HINT_W-1:0] hint_i,
   input  logic              link_en_i,
   input  logic              wide_mode_i,
   input  logic [ADDR_W-1:0] pc_i,
   input  logic [ADDR_W-1:0] count_i,
   input  logic [ADDR_W-1:0] link_i,
   input  logic [COND_W-1:0] cond_reg_i,
   output logic              done_o,
   output logic              taken_o,
   output logic [ADDR_W-1:0] next_pc_o,
   output logic [ADDR_W-1:0] count_o,
   output logic [ADDR_W-1:0] link_o
);
   localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

   opt_t              dec;
   logic [ADDR_W-1:0] count_nx, next_pc_nx, link_nx;
   logic              count_pass, cond_pass, taken_nx;
   logic              hint_unused;

   assign hint_unused = ^hint_i;

   clb_opt_decode u_dec (
      .opt_i (opt_i),
      .dec_o (dec)
   );

   clb_count_eval #(.COUNT_W(ADDR_W), .NARROW_W(NARROW_W)) u_count (
      .count_i    (count_i),
      .wide_i     (wide_mode_i),
      .skip_i     (dec.skip_count),
      .zero_pol_i (dec.zero_pol),
      .count_o    (count_nx),
      .pass_o     (count_pass)
   );

   clb_cond_eval #(.COND_W(COND_W), .MSB_FIRST(1'b1)) u_cond (
      .cond_i (cond_reg_i),
      .sel_i  (csel_i),
      .skip_i (dec.skip_cond),
      .want_i (dec.cond_want),
      .pass_o (cond_pass)
   );

   assign taken_nx = count_pass & cond_pass;

   clb_target #(.ADDR_W(ADDR_W), .STEP(STEP), .ALIGN_BITS(2)) u_tgt (
      .taken_i   (taken_nx),
      .link_en_i (link_en_i),
      .pc_i      (pc_i),
      .link_i    (link_i),
      .next_pc_o (next_pc_nx),
      .link_o    (link_nx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_o    <= 1'b0;
         taken_o   <= 1'b0;
         next_pc_o <= '0;
         count_o   <= '0;
         link_o    <= '0;
      end else begin
         done_o <= start_i;
         if (start_i) begin
            taken_o   <= taken_nx;
            next_pc_o <= next_pc_nx;
            count_o   <= count_nx;
            link_o    <= link_nx;
         end
      end
   end

   // R2: done follows the strobe by one cycle; results hold when idle
   assert_done_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> done_o);
   assert_no_spurious_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !start_i |=> !done_o);
   assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !start_i |=> ($stable(count_o) && $stable(link_o) && $stable(next_pc_o) && $stable(taken_o)));

   // R3: counter step or hold
   assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !opt_i[OPT_SKIP_COUNT]) |=> count_o == $past(count_i) - STEP_V / STEP_V);
   assert_count_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && opt_i[OPT_SKIP_COUNT]) |=> count_o == $past(count_i));

   // R7: a taken branch lands on a word-aligned address from the old link
   assert_target_aligned_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && taken_o) |-> next_pc_o[1:0] == 2'b00);

   // R8: not taken means fall through
   assert_fallthrough_R8: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (taken_o || next_pc_o == $past(pc_i) + STEP_V));

   // R9: link update independent of branch outcome
   assert_link_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && link_en_i) |=> link_o == $past(pc_i) + STEP_V);
   assert_link_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !link_en_i) |=> link_o == $past(link_i));
endmodule

// File: tb/tb_cond_link_branch.sv
module tb_cond_link_branch;
   localparam int CLK_PERIOD = 10;

   typedef struct {
      logic        taken;
      logic [63:0] next_pc;
      logic [63:0] count;
      logic [63:0] link;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [4:0]  opt_i = '0;
   logic [4:0]  csel_i = '0;
   logic [1:0]  hint_i = '0;
   logic        link_en_i = 1'b0;
   logic        wide_mode_i = 1'b1;
   logic [63:0] pc_i = '0, count_i = '0, link_i = '0;
   logic [31:0] cond_reg_i = '0;
   logic        done_o, taken_o;
   logic [63:0] next_pc_o, count_o, link_o;

   int   n_checks = 0;
   int   n_fail = 0;
   bit   finished = 1'b0;
   exp_t q[$];
   exp_t last;

   always #(CLK_PERIOD/2) clk = ~clk;

   cond_link_branch dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .opt_i(opt_i),
      .csel_i(csel_i), .hint_i(hint_i), .link_en_i(link_en_i),
      .wide_mode_i(wide_mode_i), .pc_i(pc_i), .count_i(count_i),
      .link_i(link_i), .cond_reg_i(cond_reg_i), .done_o(done_o),
      .taken_o(taken_o), .next_pc_o(next_pc_o), .count_o(count_o),
      .link_o(link_o)
   );

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Driver: sets inputs at a falling edge, raises start, pushes expectation
   task automatic issue(input bit skip_cond, input bit want, input bit skip_cnt,
                        input bit zpol, input logic [4:0] sel, input logic [31:0] cond,
                        input logic [1:0] hint, input bit len, input bit wide,
                        input logic [63:0] pc, input logic [63:0] cnt,
                        input logic [63:0] lnk, input string tag);
      exp_t e;
      logic [63:0] nc;
      bit nz, cpass, kpass;
      @(negedge clk);
      opt_i = {skip_cond, want, skip_cnt, zpol, 1'b0};
      csel_i = sel; cond_reg_i = cond; hint_i = hint; link_en_i = len;
      wide_mode_i = wide; pc_i = pc; count_i = cnt; link_i = lnk;
      start_i = 1'b1;
      nc = skip_cnt ? cnt : cnt - 64'd1;
      nz = wide ? (nc != 64'd0) : (nc[31:0] != 32'd0);
      cpass = skip_cnt || (nz != zpol);
      kpass = skip_cond || (cond[31 - sel] == want);
      e.taken = cpass && kpass;
      e.next_pc = e.taken ? {lnk[63:2], 2'b00} : pc + 64'd4;
      e.count = nc;
      e.link = len ? pc + 64'd4 : lnk;
      e.tag = tag;
      q.push_back(e);
   endtask

   task automatic idle(input int n);
      @(negedge clk);
      start_i = 1'b0;
      opt_i = 5'b00001; hint_i = 2'b11; count_i = 64'hdead; link_i = 64'hbeef;
      repeat (n) @(negedge clk);
   endtask

   // Monitor: pops and compares when a result appears
   always @(negedge clk) begin
      if (rst_n && done_o) begin
         if (q.size() == 0) begin
            check(1'b0, "R2 unexpected done", 64'(done_o), 64'd0);
         end else begin
            exp_t e;
            e = q.pop_front();
            last = e;
            check(taken_o == e.taken, {e.tag, " taken"}, 64'(taken_o), 64'(e.taken));
            check(next_pc_o == e.next_pc, {e.tag, " next R7/R8"}, next_pc_o, e.next_pc);
            check(count_o == e.count, {e.tag, " count R3"}, count_o, e.count);
            check(link_o == e.link, {e.tag, " link R9"}, link_o, e.link);
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog expired actual=%0d expected=0", q.size());
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check(done_o == 0 && taken_o == 0, "R1 reset flags", {62'd0, done_o, taken_o}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check(next_pc_o == 0 && count_o == 0 && link_o == 0, "R1 reset values",
            next_pc_o | count_o | link_o, 64'd0);
      check(done_o == 0, "R1 done after reset", 64'(done_o), 64'd0);

      // R3 R4: decrement to nonzero, branch on nonzero
      issue(1,0,0,0, 5'd0, 32'h0, 2'b00, 0, 1, 64'h2000, 64'd5, 64'h1000_0003, "R4 nonzero");
      idle(2);
      // R4: decrement to zero, branch-on-nonzero fails
      issue(1,0,0,0, 5'd0, 32'h0, 2'b00, 0, 1, 64'h2000, 64'd1, 64'h1000_0003, "R4 zero fails");
      // R4: branch on zero passes (back-to-back, R2)
      issue(1,0,0,1, 5'd0, 32'h0, 2'b00, 0, 1, 64'h2100, 64'd1, 64'h1000_0007, "R2 R4 zero passes");
      // R5: narrow mode sees low word zero
      issue(1,0,0,1, 5'd0, 32'h0, 2'b00, 0, 0, 64'h2200, 64'h1_0000_0001, 64'h4444_0001, "R5 narrow");
      // R5: wide mode sees upper bit
      issue(1,0,0,1, 5'd0, 32'h0, 2'b00, 0, 1, 64'h2200, 64'h1_0000_0001, 64'h4444_0001, "R5 wide");
      // R3: zero wraps to all ones
      issue(1,0,0,0, 5'd0, 32'h0, 2'b00, 0, 0, 64'h2300, 64'd0, 64'h0000_8002, "R3 wrap");
      // R3 R4: skip count, count held even at zero
      issue(1,0,1,0, 5'd0, 32'h0, 2'b00, 0, 1, 64'h2400, 64'd0, 64'hABCD_0000_0000_0011, "R3 skip count");
      idle(1);
      // R6: MSB selected by 0
      issue(0,1,1,0, 5'd0, 32'h8000_0000, 2'b00, 0, 1, 64'h3000, 64'd9, 64'h5556, "R6 msb pass");
      issue(0,1,1,0, 5'd31, 32'h8000_0000, 2'b00, 0, 1, 64'h3000, 64'd9, 64'h5556, "R6 lsb fail");
      issue(0,1,1,0, 5'd31, 32'h0000_0001, 2'b00, 0, 1, 64'h3000, 64'd9, 64'h5556, "R6 lsb pass");
      issue(0,0,1,0, 5'd5, 32'hFBFF_FFFF, 2'b00, 0, 1, 64'h3000, 64'd9, 64'h5556, "R6 want zero");
      // R7: both tests needed
      issue(0,1,0,0, 5'd0, 32'h8000_0000, 2'b00, 0, 1, 64'h3100, 64'd1, 64'h7777, "R7 count blocks");
      // R9: link write with taken branch uses old link
      issue(1,0,1,0, 5'd0, 32'h0, 2'b00, 1, 1, 64'h0000_0000_FFFF_FFFC, 64'd3, 64'hF0F0_F0F0_0F0F_0F0F, "R9 taken link");
      // R9: link write with not-taken branch
      issue(0,1,1,0, 5'd2, 32'h0, 2'b00, 1, 1, 64'h4000, 64'd3, 64'h1234, "R9 untaken link");
      // R10: hint and spare option bit ignored
      issue(1,0,0,0, 5'd0, 32'h0, 2'b11, 0, 1, 64'h2000, 64'd5, 64'h1000_0003, "R10 hint");
      @(negedge clk);
      opt_i = 5'b10001; start_i = 1'b1;  // spare bit set, same request
      q.push_back(q.size() == 0 ? last : q[q.size()-1]);
      idle(3);
      // R2: outputs held after idle cycles
      check(done_o == 0, "R2 idle done", 64'(done_o), 64'd0);
      check(count_o == last.count && link_o == last.link && next_pc_o == last.next_pc,
            "R2 hold", count_o, last.count);
      check(q.size() == 0, "R2 all results seen", 64'(q.size()), 64'd0);
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule